// File: doc/BRIEF.md
# Horizontal-Blank Gated Video Memory Block Copier

This block moves data from a 16-bit source address space into an 8 KiB video memory window, in units of 16 bytes. Software programs a source pointer, a destination pointer and a length/control byte through a small register port. Writing the control byte while the copier is idle launches a transfer of (length+1) units. Bit 7 of that byte picks the mode. In burst mode every unit is copied back to back, one byte per clock. In blank-gated mode one unit is copied each time the display enters horizontal blank.

The block presents a read address toward the source and takes the read data back in the same cycle. It forwards that byte, with a write strobe and address, toward video memory. Its busy output is high in exactly the cycles in which a byte moves, so surrounding logic can hold the processor off the buses. A control write issued while a gated transfer is running either lets it go on or cancels it, and in both cases snaps both pointers back to the start of their current unit.

Top module: `vram_blank_dma`

## Requirements
- R1: After reset busy is low, vram_we is low, and a read of the control register (reg_addr 4) returns 0x80.
- R2: The source pointer takes reg_wdata as bits 15:8 on a write to reg_addr 0. A write to reg_addr 1 sets bits 7:4 from reg_wdata[7:4] and clears bits 3:0. src_addr shows this pointer while a byte moves and counts up by one per byte moved.
- R3: Writing reg_addr 2 keeps reg_wdata[4:0] as destination bits 12:8. Writing reg_addr 3 keeps reg_wdata[7:4] as bits 7:4 and clears bits 3:0. vram_addr is always {3'b100, pointer[12:0]}, so it stays in 0x8000..0x9FFF and steps by one per byte within that window.
- R4: An idle write of reg_wdata to reg_addr 4 with bit 7 clear starts burst mode. Busy rises in the cycle after the write and stays high for exactly 16*(reg_wdata[6:0]+1) consecutive cycles. In each busy cycle vram_we is high and vram_wdata equals src_rdata of that cycle.
- R5: When the last unit completes, busy falls and the control register reads 0xFF (bit 7 set, remaining length 0x7F).
- R6: While a transfer is active, control-register bit 7 reads 0. Bits 6:0 read the remaining length, which drops by one at the end of each 16-byte unit.
- R7: An idle control write with bit 7 set starts blank-gated mode. No byte moves until hblank goes from low to high. Busy then rises one cycle after the first high cycle and lasts 16 cycles. hblank staying high does not arm another unit.
- R8: Starting a transfer forgets the previous hblank level. If hblank is already high at the start, a unit is armed and busy rises in the second cycle after the write.
- R9: A control write during an active transfer loads the length from reg_wdata[6:0] and clears bits 3:0 of both pointers. With reg_wdata[7] clear it ends the transfer: busy is low from the next cycle and later hblank rises move nothing. With reg_wdata[7] set the transfer continues.
- R10: Reads of reg_addr 0 to 3 return 0xFF.
- R11: An hblank rise in the cycle that moves the final byte of a unit arms the next unit, so busy stays high without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select (0 src high, 1 src low, 2 dst high, 3 dst low, 4 control) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| hblank | input | 1 | High while the display is in horizontal blank |
| busy | output | 1 | A byte is being moved this cycle |
| src_addr | output | 16 | Source read address |
| src_rdata | input | 8 | Source read data for src_addr, same cycle |
| vram_we | output | 1 | Video memory write strobe |
| vram_addr | output | 16 | Video memory write address |
| vram_wdata | output | 8 | Video memory write data |

## Verification
Two events can land in the same cycle: a gated unit finishing, which clears the pending flag, and a fresh hblank rise, which sets it. The bench drops hblank in the cycle that moves the fifteenth byte and raises it in the cycle of the sixteenth. It then requires busy to stay high straight into the next unit, with 32 busy cycles in total and every byte matched by the scoreboard. A second overlap is a control write landing on a cycle that also moves a byte. The bench writes mid-unit and expects the moved byte to be kept, followed by a full unit restarted from the unit base.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

    localparam int REG_SEL_W = 3;

    typedef enum logic [REG_SEL_W-1:0] {
        SEL_SRC_HI = 3'd0,
        SEL_SRC_LO = 3'd1,
        SEL_DST_HI = 3'd2,
        SEL_DST_LO = 3'd3,
        SEL_CTRL   = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/vdma_edge_det.sv
module vdma_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic forget,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = forget ? 1'b0 : level;
        rise   = level & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/vdma_step.sv
module vdma_step #(
    parameter int SRC_W    = 16,
    parameter int OFF_W    = 13,
    parameter int LEN_W    = 7,
    parameter int BLK_LOG2 = 4
) (
    input  logic [SRC_W-1:0] src,
    input  logic [OFF_W-1:0] dst,
    input  logic [LEN_W-1:0] len,
    output logic [SRC_W-1:0] src_nx,
    output logic [OFF_W-1:0] dst_nx,
    output logic [LEN_W-1:0] len_nx,
    output logic             blk_done,
    output logic             last_blk
);
    always_comb begin
        src_nx   = src + 1'b1;
        dst_nx   = dst + 1'b1;
        len_nx   = len - 1'b1;
        blk_done = &dst[BLK_LOG2-1:0];
        last_blk = (len == '0);
    end
endmodule

// File: rtl/vdma_rd_mux.sv
module vdma_rd_mux #(
    parameter int DW    = 8,
    parameter int LEN_W = 7
) (
    input  vdma_pkg::reg_sel_e rd_sel,
    input  logic               active,
    input  logic [LEN_W-1:0]   len,
    output logic [DW-1:0]      rdata
);
    localparam int PAD_W = DW - LEN_W;

    always_comb begin
        if (rd_sel == vdma_pkg::SEL_CTRL) rdata = {{PAD_W{~active}}, len};
        else                              rdata = '1;
    end
endmodule

// File: rtl/vram_blank_dma.sv
module vram_blank_dma #(
    parameter int SRC_W    = 16,
    parameter int OFF_W    = 13,
    parameter int LEN_W    = 7,
    parameter int BLK_LOG2 = 4,
    parameter int DW       = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           reg_wr,
    input  logic [vdma_pkg::REG_SEL_W-1:0] reg_addr,
    input  logic [DW-1:0]                  reg_wdata,
    output logic [DW-1:0]                  reg_rdata,
    input  logic                           hblank,
    output logic                           busy,
    output logic [SRC_W-1:0]               src_addr,
    input  logic [DW-1:0]                  src_rdata,
    output logic                           vram_we,
    output logic [SRC_W-1:0]               vram_addr,
    output logic [DW-1:0]                  vram_wdata
);
    import vdma_pkg::*;

    localparam int                WIN_W    = SRC_W - OFF_W;
    localparam logic [WIN_W-1:0]  WIN_TAG  = WIN_W'(1) << (WIN_W - 1);
    localparam int                MODE_BIT = DW - 1;
    localparam int                HI_W     = OFF_W - DW;
    localparam int                LO_KEEP  = DW - BLK_LOG2;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [OFF_W-1:0] dst;
        logic [LEN_W-1:0] len;
        logic             active;
        logic             gated;
        logic             pending;
    } st_t;

    st_t s_d, s_q;

    logic             hb_rise;
    logic             forget_hb;
    logic             move;
    logic [SRC_W-1:0] src_nx;
    logic [OFF_W-1:0] dst_nx;
    logic [LEN_W-1:0] len_nx;
    logic             blk_done;
    logic             last_blk;
    reg_sel_e         sel;

    assign sel = reg_sel_e'(reg_addr);

    vdma_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (hblank),
        .forget (forget_hb),
        .rise   (hb_rise)
    );

    vdma_step #(
        .SRC_W    (SRC_W),
        .OFF_W    (OFF_W),
        .LEN_W    (LEN_W),
        .BLK_LOG2 (BLK_LOG2)
    ) u_step (
        .src      (s_q.src),
        .dst      (s_q.dst),
        .len      (s_q.len),
        .src_nx   (src_nx),
        .dst_nx   (dst_nx),
        .len_nx   (len_nx),
        .blk_done (blk_done),
        .last_blk (last_blk)
    );

    vdma_rd_mux #(
        .DW    (DW),
        .LEN_W (LEN_W)
    ) u_rd (
        .rd_sel (sel),
        .active (s_q.active),
        .len    (s_q.len),
        .rdata  (reg_rdata)
    );

    always_comb begin
        s_d       = s_q;
        forget_hb = 1'b0;
        move      = s_q.active && (!s_q.gated || s_q.pending);

        // byte advance and unit completion
        if (move) begin
            s_d.src = src_nx;
            s_d.dst = dst_nx;
            if (blk_done) begin
                s_d.pending = 1'b0;
                s_d.len     = len_nx;
                if (last_blk) s_d.active = 1'b0;
            end
        end

        // a fresh blank entry arms a unit; it wins over the completion clear
        if (s_q.active && s_q.gated && hb_rise) s_d.pending = 1'b1;

        // register writes take priority over the advance
        if (reg_wr) begin
            unique case (sel)
                SEL_SRC_HI: s_d.src[SRC_W-1 -: DW] = reg_wdata;
                SEL_SRC_LO: s_d.src[DW-1:0] = {reg_wdata[DW-1 -: LO_KEEP], {BLK_LOG2{1'b0}}};
                SEL_DST_HI: s_d.dst[OFF_W-1:DW] = reg_wdata[HI_W-1:0];
                SEL_DST_LO: s_d.dst[DW-1:0] = {reg_wdata[DW-1 -: LO_KEEP], {BLK_LOG2{1'b0}}};
                SEL_CTRL: begin
                    s_d.len = reg_wdata[LEN_W-1:0];
                    if (s_q.active) begin
                        s_d.active                = reg_wdata[MODE_BIT];
                        s_d.src[BLK_LOG2-1:0]     = '0;
                        s_d.dst[BLK_LOG2-1:0]     = '0;
                    end else begin
                        s_d.active  = 1'b1;
                        s_d.gated   = reg_wdata[MODE_BIT];
                        s_d.pending = 1'b0;
                        forget_hb   = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        busy       = move;
        vram_we    = move;
        src_addr   = s_q.src;
        vram_addr  = {WIN_TAG, s_q.dst};
        vram_wdata = src_rdata;
    end
endmodule

// File: rtl/vdma_chk.sv
module vdma_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [2:0]  reg_addr,
    input logic [7:0]  reg_wdata,
    input logic [7:0]  reg_rdata,
    input logic        busy,
    input logic [15:0] src_addr,
    input logic        vram_we,
    input logic [15:0] vram_addr
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R3
    dst_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vram_we |-> vram_addr[15:13] == 3'b100);

    // R3
    dst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && busy && $past(busy) && !$past(reg_wr)
        |-> vram_addr[12:0] == $past(vram_addr[12:0]) + 13'd1);

    // R2
    src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && busy && $past(busy) && !$past(reg_wr)
        |-> src_addr == $past(src_addr) + 16'd1);

    // R6
    busy_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && reg_addr == 3'd4 |-> !reg_rdata[7]);

    // R10
    ptr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr < 3'd4 |-> reg_rdata == 8'hFF);

    // R9
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(reg_wr && reg_addr == 3'd4 && !reg_wdata[7] && busy) |-> !busy);
endmodule

bind vram_blank_dma vdma_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .src_addr  (src_addr),
    .vram_we   (vram_we),
    .vram_addr (vram_addr)
);

// File: tb/tb_vram_blank_dma.sv
module tb_vram_blank_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        hblank = 1'b0;
    logic        busy;
    logic [15:0] src_addr;
    logic [7:0]  src_rdata;
    logic        vram_we;
    logic [15:0] vram_addr;
    logic [7:0]  vram_wdata;

    int total = 0;
    int bad = 0;
    int busy_cnt = 0;
    bit finished = 0;
    logic [23:0] exp_q[$];

    always #2 clk = ~clk;

    function automatic logic [7:0] src_model(input logic [15:0] a);
        return a[15:8] ^ a[7:0] ^ 8'hA5;
    endfunction

    assign src_rdata = src_model(src_addr);

    vram_blank_dma dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .hblank     (hblank),
        .busy       (busy),
        .src_addr   (src_addr),
        .src_rdata  (src_rdata),
        .vram_we    (vram_we),
        .vram_addr  (vram_addr),
        .vram_wdata (vram_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_bytes(input logic [15:0] s, input logic [12:0] d, input int n);
        for (int i = 0; i < n; i++) begin
            logic [15:0] sa;
            logic [12:0] da;
            sa = s + 16'(i);
            da = d + 13'(i);
            exp_q.push_back({3'b100, da, src_model(sa)});
        end
    endtask

    // monitor: pops expected writes as the design produces them
    always @(negedge clk) begin
        #1;
        if (rst_n && busy) busy_cnt++;
        if (rst_n && vram_we) begin
            if (exp_q.size() == 0) begin
                chk("R4 unexpected vram write", {16'd0, vram_addr}, 32'hFFFF_FFFF);
            end else begin
                logic [23:0] it;
                it = exp_q.pop_front();
                chk("R3 vram_addr", {16'd0, vram_addr}, {16'd0, it[23:8]});
                chk("R2 R4 vram_wdata", {24'd0, vram_wdata}, {24'd0, it[7:0]});
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 3'd0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 2000) begin @(negedge clk); n++; end
        repeat (2) @(negedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", {31'd0, busy}, 0);
        chk("R1 vram_we", {31'd0, vram_we}, 0);
        rd(3'd4, v); chk("R1 status", {24'd0, v}, 32'h80);
        @(negedge clk);

        // R4 burst mode, 3 units, with masking of R2 R3
        wr(3'd0, 8'h12); wr(3'd1, 8'h3F); wr(3'd2, 8'hE5); wr(3'd3, 8'h67);
        for (int a = 0; a < 4; a++) begin
            rd(3'(a), v); chk("R10 pointer read", {24'd0, v}, 32'hFF);
        end
        push_bytes(16'h1230, 13'h0560, 48);
        busy_cnt = 0;
        wr(3'd4, 8'h02);
        chk("R4 busy next cycle", {31'd0, busy}, 1);
        chk("R2 first src_addr", {16'd0, src_addr}, 32'h1230);
        repeat (17) @(negedge clk);
        rd(3'd4, v); chk("R6 status mid transfer", {24'd0, v}, 32'h01);
        wait_idle();
        chk("R4 busy length", busy_cnt, 48);
        chk("R4 queue drained", exp_q.size(), 0);
        rd(3'd4, v); chk("R5 status at end", {24'd0, v}, 32'hFF);
        @(negedge clk);

        // R7 blank-gated, 2 units
        wr(3'd0, 8'h40); wr(3'd1, 8'h00); wr(3'd2, 8'h01); wr(3'd3, 8'h00);
        push_bytes(16'h4000, 13'h0100, 32);
        wr(3'd4, 8'h81);
        repeat (5) @(negedge clk);
        chk("R7 no move before blank", {31'd0, busy}, 0);
        busy_cnt = 0;
        hblank = 1'b1;
        @(negedge clk);
        chk("R7 busy one cycle after rise", {31'd0, busy}, 1);
        repeat (40) @(negedge clk);
        #2;
        chk("R7 one unit per rise", busy_cnt, 16);
        rd(3'd4, v); chk("R6 status after one unit", {24'd0, v}, 32'h00);
        hblank = 1'b0;
        repeat (3) @(negedge clk);
        hblank = 1'b1;
        repeat (30) @(negedge clk);
        #2;
        chk("R7 second unit", busy_cnt, 32);
        chk("R7 queue drained", exp_q.size(), 0);
        rd(3'd4, v); chk("R5 gated end status", {24'd0, v}, 32'hFF);
        @(negedge clk);

        // R8 start while hblank already high
        wr(3'd0, 8'h55); wr(3'd1, 8'hA0); wr(3'd2, 8'h1A); wr(3'd3, 8'hC0);
        push_bytes(16'h55A0, 13'h1AC0, 16);
        busy_cnt = 0;
        wr(3'd4, 8'h80);
        chk("R8 idle in first cycle", {31'd0, busy}, 0);
        @(negedge clk);
        chk("R8 busy in second cycle", {31'd0, busy}, 1);
        wait_idle();
        chk("R8 one unit", busy_cnt, 16);
        chk("R8 queue drained", exp_q.size(), 0);

        // R9 mid-unit control write that continues, then a stop
        hblank = 1'b0;
        wr(3'd0, 8'h2A); wr(3'd1, 8'h5F); wr(3'd2, 8'h1F); wr(3'd3, 8'hFF);
        push_bytes(16'h2A50, 13'h1FF0, 6);
        push_bytes(16'h2A50, 13'h1FF0, 16);
        wr(3'd4, 8'h81);
        hblank = 1'b1;
        @(negedge clk);
        chk("R7 gated arm", {31'd0, busy}, 1);
        repeat (5) @(negedge clk);
        wr(3'd4, 8'h83);
        chk("R9 continue keeps busy", {31'd0, busy}, 1);
        chk("R9 src snapped to unit base", {16'd0, src_addr}, 32'h2A50);
        wait_idle();
        chk("R9 queue drained", exp_q.size(), 0);
        rd(3'd4, v); chk("R9 length reloaded", {24'd0, v}, 32'h02);
        @(negedge clk);
        wr(3'd4, 8'h00);
        rd(3'd4, v); chk("R9 stop status", {24'd0, v}, 32'h80);
        busy_cnt = 0;
        hblank = 1'b0;
        repeat (3) @(negedge clk);
        hblank = 1'b1;
        repeat (10) @(negedge clk);
        #2;
        chk("R9 no move after stop", busy_cnt, 0);

        // R11 blank rise in the cycle of a unit's last byte
        hblank = 1'b0;
        wr(3'd0, 8'h01); wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h40);
        push_bytes(16'h0100, 13'h0040, 32);
        wr(3'd4, 8'h81);
        busy_cnt = 0;
        hblank = 1'b1;
        @(negedge clk);
        chk("R11 first unit armed", {31'd0, busy}, 1);
        repeat (14) @(negedge clk);
        hblank = 1'b0;
        @(negedge clk);
        hblank = 1'b1;
        @(negedge clk);
        chk("R11 no gap into next unit", {31'd0, busy}, 1);
        wait_idle();
        chk("R11 total busy", busy_cnt, 32);
        chk("R11 queue drained", exp_q.size(), 0);
        rd(3'd4, v); chk("R5 final status", {24'd0, v}, 32'hFF);

        finish_run();
    end
endmodule